// File: doc/BRIEF.md
# Inbound Interrupt Message Forwarder

This block merges inbound memory write requests from two upstream ports into one shared posted-write buffer and forwards them, in posting order, to a host-side output channel. Each request is answered in the same cycle it is presented. It is either posted into the buffer, or the requester is told to retry and must present the whole request again later. A retried request leaves no trace in the block.

Writes are not classified on the way in. A write headed for the interrupt window travels through the same buffer as every other write. Only when an entry reaches the head of the buffer is its address decoded. An entry whose upper address bits equal the window tag `0xFEE` leaves as an interrupt message transaction. Every other entry leaves as an ordinary memory write. The hub port always qualifies for interrupt forwarding. The graphics port qualifies only when the request carries the PCI-semantics flag. Because the buffer is strictly first-in first-out, an interrupt message can never overtake a write that was posted before it.

When both ports request in the same cycle, a round-robin priority bit decides which port is posted first. Free space is the occupancy limit, capped at the buffer depth, minus the current occupancy. A pop in the same cycle does not add to this free space.

Top module: `intr_msg_fwd`

## Requirements
- R1: After reset `host_valid` is 0, the buffer is empty, and the first cycle with both ports requesting favours the hub port.
- R2: A lone request on either port is accepted in the same cycle when occupancy is below the effective limit, and retried otherwise.
- R3: The effective limit is the smaller of `occ_limit` and the buffer depth. No write is accepted while occupancy is at or above it, so `occ_limit` of 0 retries every request.
- R4: When both ports request and at least two slots are free, both are accepted. The priority port's write is posted first and leaves the output first.
- R5: When both ports request and exactly one slot is free, only the priority port is accepted and the other is retried. After any cycle with both ports requesting and at least one accepted, priority passes to the other port.
- R6: Entries leave on `host_addr`/`host_data` unchanged and in the order they were posted. `host_valid` is 1 exactly while the buffer holds an entry, and an entry is removed in a cycle with `host_valid` and `host_ready` both 1.
- R7: An entry posted from the hub port leaves with `host_type` 1 (interrupt message) when address bits [31:20] equal 0xFEE, and with `host_type` 0 (memory write) otherwise.
- R8: An entry posted from the graphics port leaves with `host_type` 1 only when `gfx_pci_sem` was 1 with the request and address bits [31:20] equal 0xFEE. In every other case it leaves with `host_type` 0.
- R9: A retried request changes neither the occupancy nor the stream of entries seen at the output.
- R10: While `host_valid` is 1 and `host_ready` is 0, `host_valid`, `host_type`, `host_addr` and `host_data` hold their values.
- R11: For each port, exactly one of accept and retry is 1 in a cycle where its valid is 1, and neither is 1 when its valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hub_valid | input | 1 | Hub port write request |
| hub_addr | input | AW (32) | Hub port write address |
| hub_data | input | DW (32) | Hub port write data |
| hub_accept | output | 1 | Hub request posted this cycle |
| hub_retry | output | 1 | Hub request refused, present again |
| gfx_valid | input | 1 | Graphics port write request |
| gfx_pci_sem | input | 1 | Graphics request uses PCI semantics |
| gfx_addr | input | AW (32) | Graphics port write address |
| gfx_data | input | DW (32) | Graphics port write data |
| gfx_accept | output | 1 | Graphics request posted this cycle |
| gfx_retry | output | 1 | Graphics request refused, present again |
| occ_limit | input | $clog2(DEPTH)+1 | Occupancy limit for posting |
| host_valid | output | 1 | Output entry available |
| host_ready | input | 1 | Host side takes the entry |
| host_type | output | 1 | 0 memory write, 1 interrupt message |
| host_addr | output | AW (32) | Entry address |
| host_data | output | DW (32) | Entry data |

## Verification
The bench builds the block with DEPTH set to 4, leaving the address and data widths at 32. A shallow buffer fills, wraps its pointers and reaches the one-free-slot tie many times during a short random run, so the cases where priority decides who is retried come up often. The `occ_limit` values the bench drives include 0, values below the depth and values above it, so the cap on the limit is also exercised. Addresses are biased toward the interrupt window, and the PCI-semantics flag is driven independently, so every combination of source, flag and window match reaches the output.

// File: rtl/intr_msg_fwd_pkg.sv
package intr_msg_fwd_pkg;

  // Transaction type carried on the host channel
  typedef enum logic {
    XACT_MEMWR  = 1'b0,
    XACT_INTMSG = 1'b1
  } xact_e;

  // Width of the address tag that selects the interrupt window
  localparam int unsigned WIN_TAG_W = 12;

endpackage

// File: rtl/intr_msg_fwd_arb.sv
// Post-or-retry decision and round-robin priority between the two ports.
module intr_msg_fwd_arb #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hub_valid,
  input  logic             gfx_valid,
  input  logic [CNT_W-1:0] occ_count,
  input  logic [CNT_W-1:0] occ_limit,
  output logic             hub_accept,
  output logic             gfx_accept,
  output logic             first_gfx
);

  logic             prio_gfx_q, prio_gfx_d;
  logic [CNT_W-1:0] eff_lim;
  logic [CNT_W-1:0] free_slots;
  logic             both;

  always_comb begin
    eff_lim    = (occ_limit > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : occ_limit;
    free_slots = (occ_count >= eff_lim) ? '0 : (eff_lim - occ_count);
    both       = hub_valid & gfx_valid;
    hub_accept = 1'b0;
    gfx_accept = 1'b0;
    if (both) begin
      if (prio_gfx_q) begin
        gfx_accept = (free_slots >= CNT_W'(1));
        hub_accept = (free_slots >= CNT_W'(2));
      end else begin
        hub_accept = (free_slots >= CNT_W'(1));
        gfx_accept = (free_slots >= CNT_W'(2));
      end
    end else begin
      hub_accept = hub_valid & (free_slots != '0);
      gfx_accept = gfx_valid & (free_slots != '0);
    end
    first_gfx  = both ? prio_gfx_q : gfx_valid;
    prio_gfx_d = prio_gfx_q;
    if (both && (hub_accept || gfx_accept)) begin
      prio_gfx_d = ~prio_gfx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_gfx_q <= 1'b0;
    end else begin
      prio_gfx_q <= prio_gfx_d;
    end
  end

endmodule

// File: rtl/intr_msg_fwd_fifo.sv
// Posted-write buffer: up to two writes and one read per cycle.
// DEPTH must be a power of two so that the pointers wrap naturally.
module intr_msg_fwd_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned EW    = 65,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr0_en,
  input  logic [EW-1:0]    wr0_data,
  input  logic             wr1_en,
  input  logic [EW-1:0]    wr1_data,
  input  logic             rd_en,
  output logic [EW-1:0]    rd_data,
  output logic [CNT_W-1:0] count
);

  logic [EW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] wptr_nx;

  always_comb begin
    wptr_nx = wptr_q + PTR_W'(1);
    wptr_d  = wptr_q + PTR_W'(wr0_en) + PTR_W'(wr1_en);
    rptr_d  = rptr_q + PTR_W'(rd_en);
    cnt_d   = cnt_q + CNT_W'(wr0_en) + CNT_W'(wr1_en) - CNT_W'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage carries no reset; only pointers qualify its contents.
  always_ff @(posedge clk) begin
    if (wr0_en) begin
      mem[wptr_q] <= wr0_data;
    end
    if (wr1_en) begin
      mem[wptr_nx] <= wr1_data;
    end
  end

  assign rd_data = mem[rptr_q];
  assign count   = cnt_q;

endmodule

// File: rtl/intr_msg_fwd_cls.sv
// Head-of-buffer decode: window match decides the transaction type.
module intr_msg_fwd_cls
  import intr_msg_fwd_pkg::*;
#(
  parameter int unsigned          AW      = 32,
  parameter int unsigned          DW      = 32,
  parameter logic [WIN_TAG_W-1:0] WIN_TAG = 12'hFEE,
  localparam int unsigned EW = AW + DW + 1
) (
  input  logic [EW-1:0] entry,
  output xact_e         xtype,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  logic qual;
  logic in_win;

  always_comb begin
    qual   = entry[EW-1];
    addr   = entry[DW +: AW];
    data   = entry[DW-1:0];
    in_win = (addr[AW-1 -: WIN_TAG_W] == WIN_TAG);
    xtype  = (qual && in_win) ? XACT_INTMSG : XACT_MEMWR;
  end

endmodule

// File: rtl/intr_msg_fwd.sv
module intr_msg_fwd
  import intr_msg_fwd_pkg::*;
#(
  parameter int unsigned          DEPTH   = 8,
  parameter int unsigned          AW      = 32,
  parameter int unsigned          DW      = 32,
  parameter logic [WIN_TAG_W-1:0] WIN_TAG = 12'hFEE,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1,
  localparam int unsigned EW    = AW + DW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hub_valid,
  input  logic [AW-1:0]    hub_addr,
  input  logic [DW-1:0]    hub_data,
  output logic             hub_accept,
  output logic             hub_retry,
  input  logic             gfx_valid,
  input  logic             gfx_pci_sem,
  input  logic [AW-1:0]    gfx_addr,
  input  logic [DW-1:0]    gfx_data,
  output logic             gfx_accept,
  output logic             gfx_retry,
  input  logic [CNT_W-1:0] occ_limit,
  output logic             host_valid,
  input  logic             host_ready,
  output logic             host_type,
  output logic [AW-1:0]    host_addr,
  output logic [DW-1:0]    host_data
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic [CNT_W-1:0] occ_count;
  logic             first_gfx;
  logic             wr0_en, wr1_en, rd_en;
  logic [EW-1:0]    ent_hub, ent_gfx, wr0_data, wr1_data, head;
  xact_e            head_type;

  intr_msg_fwd_arb #(.DEPTH(DEPTH)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .hub_valid  (hub_valid),
    .gfx_valid  (gfx_valid),
    .occ_count  (occ_count),
    .occ_limit  (occ_limit),
    .hub_accept (hub_accept),
    .gfx_accept (gfx_accept),
    .first_gfx  (first_gfx)
  );

  // The hub port always qualifies; the graphics port only with PCI semantics
  always_comb begin
    ent_hub   = {1'b1, hub_addr, hub_data};
    ent_gfx   = {gfx_pci_sem, gfx_addr, gfx_data};
    wr0_data  = first_gfx ? ent_gfx : ent_hub;
    wr1_data  = first_gfx ? ent_hub : ent_gfx;
    wr0_en    = first_gfx ? gfx_accept : hub_accept;
    wr1_en    = hub_accept & gfx_accept;
    hub_retry = hub_valid & ~hub_accept;
    gfx_retry = gfx_valid & ~gfx_accept;
  end

  intr_msg_fwd_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr0_en   (wr0_en),
    .wr0_data (wr0_data),
    .wr1_en   (wr1_en),
    .wr1_data (wr1_data),
    .rd_en    (rd_en),
    .rd_data  (head),
    .count    (occ_count)
  );

  intr_msg_fwd_cls #(.AW(AW), .DW(DW), .WIN_TAG(WIN_TAG)) u_cls (
    .entry (head),
    .xtype (head_type),
    .addr  (host_addr),
    .data  (host_data)
  );

  always_comb begin
    host_valid = (occ_count != '0);
    host_type  = (head_type == XACT_INTMSG);
    rd_en      = host_valid & host_ready;
  end

endmodule

// File: rtl/intr_msg_fwd_chk.sv
module intr_msg_fwd_chk #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter logic [11:0] WIN_TAG = 12'hFEE,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hub_valid,
  input logic             hub_accept,
  input logic             hub_retry,
  input logic             gfx_valid,
  input logic             gfx_accept,
  input logic             gfx_retry,
  input logic [CNT_W-1:0] occ_limit,
  input logic             host_valid,
  input logic             host_ready,
  input logic             host_type,
  input logic [AW-1:0]    host_addr,
  input logic [DW-1:0]    host_data
);

  logic [CNT_W:0] occ_q;
  logic [CNT_W:0] lim_c;

  always_comb begin
    lim_c = ({1'b0, occ_limit} > (CNT_W+1)'(DEPTH)) ? (CNT_W+1)'(DEPTH)
                                                    : {1'b0, occ_limit};
  end

  // Occupancy rebuilt from port activity only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else begin
      occ_q <= occ_q + (CNT_W+1)'(hub_accept) + (CNT_W+1)'(gfx_accept)
                     - (CNT_W+1)'(host_valid & host_ready);
    end
  end

  p_hub_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hub_valid ? (hub_accept != hub_retry) : (!hub_accept && !hub_retry));
  p_gfx_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_valid ? (gfx_accept != gfx_retry) : (!gfx_accept && !gfx_retry));
  p_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_accept || gfx_accept) |-> (occ_q < lim_c));
  p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_accept && gfx_accept) |-> ((occ_q + (CNT_W+1)'(2)) <= lim_c));
  p_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == '0) |-> !host_valid);
  p_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q != '0) |-> host_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_ready) |=> (host_valid && $stable(host_type)
      && $stable(host_addr) && $stable(host_data)));
  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_type) |-> (host_addr[AW-1 -: 12] == WIN_TAG));

endmodule

bind intr_msg_fwd intr_msg_fwd_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .WIN_TAG(WIN_TAG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .hub_valid  (hub_valid),
  .hub_accept (hub_accept),
  .hub_retry  (hub_retry),
  .gfx_valid  (gfx_valid),
  .gfx_accept (gfx_accept),
  .gfx_retry  (gfx_retry),
  .occ_limit  (occ_limit),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .host_type  (host_type),
  .host_addr  (host_addr),
  .host_data  (host_data)
);

// File: tb/intr_msg_fwd_tb.sv
module intr_msg_fwd_tb;

  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic clk, rst_n;
  logic hub_valid, gfx_valid, gfx_pci_sem, host_ready;
  logic [31:0] hub_addr, hub_data, gfx_addr, gfx_data;
  logic hub_accept, hub_retry, gfx_accept, gfx_retry;
  logic [CNT_W-1:0] occ_limit;
  logic host_valid, host_type;
  logic [31:0] host_addr, host_data;

  intr_msg_fwd #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .hub_valid(hub_valid), .hub_addr(hub_addr), .hub_data(hub_data),
    .hub_accept(hub_accept), .hub_retry(hub_retry),
    .gfx_valid(gfx_valid), .gfx_pci_sem(gfx_pci_sem),
    .gfx_addr(gfx_addr), .gfx_data(gfx_data),
    .gfx_accept(gfx_accept), .gfx_retry(gfx_retry),
    .occ_limit(occ_limit),
    .host_valid(host_valid), .host_ready(host_ready), .host_type(host_type),
    .host_addr(host_addr), .host_data(host_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic        typ;
    logic        from_gfx;
  } ent_t;

  ent_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   prio_gfx = 0;
  bit   stalled = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_type(input logic [31:0] a, input bit gfx, input bit pci);
    return (a[31:20] == 12'hFEE) && (!gfx || pci);
  endfunction

  // returns {gfx_acc, hub_acc}
  function automatic logic [1:0] exp_acc(input bit hv, input bit gv, input int cnt,
                                         input int lim, input bit pg);
    int eff, fr;
    eff = (lim > DEPTH) ? DEPTH : lim;
    fr  = (cnt >= eff) ? 0 : eff - cnt;
    if (hv && gv) begin
      if (pg) return {fr >= 1, fr >= 2};
      else    return {fr >= 2, fr >= 1};
    end
    return {gv && fr >= 1, hv && fr >= 1};
  endfunction

  task automatic step(input bit hv, input logic [31:0] ha, input logic [31:0] hd,
                      input bit gv, input bit gp, input logic [31:0] ga,
                      input logic [31:0] gd, input int lim, input bit rdy);
    logic [1:0] e;
    ent_t eh, eg;
    string t;
    @(negedge clk);
    hub_valid = hv; hub_addr = ha; hub_data = hd;
    gfx_valid = gv; gfx_pci_sem = gp; gfx_addr = ga; gfx_data = gd;
    occ_limit = CNT_W'(lim); host_ready = rdy;
    #2;
    e = exp_acc(hv, gv, q.size(), lim, prio_gfx);
    if (hv && gv) t = (e != 2'b11) ? "R5 tie" : "R4 pair";
    else if (e == 2'b00 && (hv || gv)) t = "R3 limit retry";
    else t = "R2 single";
    chk(hub_accept == e[0] && hub_retry == (hv && !e[0]), {t, " hub"},
        {hub_accept, hub_retry}, {e[0], hv && !e[0]});
    chk(gfx_accept == e[1] && gfx_retry == (gv && !e[1]), {t, " gfx"},
        {gfx_accept, gfx_retry}, {e[1], gv && !e[1]});
    chk(!(hub_accept && hub_retry) && !(gfx_accept && gfx_retry), "R11 exclusive",
        {hub_accept, hub_retry, gfx_accept, gfx_retry}, 0);
    if (q.size() == 0) begin
      chk(host_valid == 1'b0, "R6 empty output", host_valid, 0);
    end else begin
      t = stalled ? "R10 hold" : "R6 R9 order";
      chk(host_valid && host_addr == q[0].addr && host_data == q[0].data,
          t, {host_addr, host_data}, {q[0].addr, q[0].data});
      chk(host_type == q[0].typ, q[0].from_gfx ? "R8 gfx type" : "R7 hub type",
          host_type, q[0].typ);
    end
    stalled = (q.size() != 0) && !rdy;
    // model update for the coming edge
    if (q.size() != 0 && rdy) void'(q.pop_front());
    eh = '{ha, hd, exp_type(ha, 0, 0), 0};
    eg = '{ga, gd, exp_type(ga, 1, gp), 1};
    if (hv && gv) begin
      if (prio_gfx) begin
        if (e[1]) q.push_back(eg);
        if (e[0]) q.push_back(eh);
      end else begin
        if (e[0]) q.push_back(eh);
        if (e[1]) q.push_back(eg);
      end
      if (e != 2'b00) prio_gfx = !prio_gfx;
    end else begin
      if (e[0]) q.push_back(eh);
      if (e[1]) q.push_back(eg);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2 * DEPTH + 2; i++)
      step(0, 0, 0, 0, 0, 0, 0, DEPTH, 1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 0; hub_valid = 0; gfx_valid = 0; gfx_pci_sem = 0; host_ready = 0;
    hub_addr = 0; hub_data = 0; gfx_addr = 0; gfx_data = 0; occ_limit = DEPTH;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #2;
    chk(host_valid == 0, "R1 reset empty", host_valid, 0);

    // R1 R4: first pair favours hub, second pair favours gfx
    step(1, 32'h1000_0000, 32'h11, 1, 1, 32'h2000_0000, 32'h22, DEPTH, 0);
    step(1, 32'h1000_0004, 32'h33, 1, 1, 32'h2000_0004, 32'h44, DEPTH, 0);
    drain();

    // R7 R8: window decode per source and flag
    step(1, 32'hFEE0_1000, 32'h1, 0, 0, 0, 0, DEPTH, 0);
    step(1, 32'hFED0_1000, 32'h2, 0, 0, 0, 0, DEPTH, 0);
    step(0, 0, 0, 1, 0, 32'hFEEF_FFFC, 32'h3, DEPTH, 0);
    step(0, 0, 0, 1, 1, 32'hFEE0_0000, 32'h4, DEPTH, 0);
    step(0, 0, 0, 0, 0, 0, 0, DEPTH, 0);           // R10 stall
    drain();

    // R3: limit 2 then limit 0, R9 retried writes never appear
    for (int i = 0; i < 4; i++)
      step(1, 32'h3000_0000 + i, i, 0, 0, 0, 0, 2, 0);
    step(0, 0, 0, 1, 1, 32'hFEE0_0000, 32'h99, 0, 0);
    drain();
    step(1, 32'h4000_0000, 1, 1, 0, 32'h5000_0000, 2, 0, 0);
    drain();

    // R5: one free slot with both requesting, then the other side wins next
    step(1, 32'h6000_0000, 1, 0, 0, 0, 0, DEPTH, 0);
    step(1, 32'h6000_0004, 2, 0, 0, 0, 0, DEPTH, 0);
    step(1, 32'h6000_0008, 3, 0, 0, 0, 0, DEPTH, 0);
    step(1, 32'h6000_000C, 4, 1, 1, 32'h7000_0000, 5, DEPTH, 0);
    step(0, 0, 0, 0, 0, 0, 0, DEPTH, 1);
    step(1, 32'h6000_0010, 6, 1, 1, 32'h7000_0004, 7, DEPTH, 0);
    drain();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ha, ga;
      int lim;
      ha = $urandom; ga = $urandom;
      if ($urandom_range(0, 9) < 4) ha[31:20] = 12'hFEE;
      if ($urandom_range(0, 9) < 4) ga[31:20] = 12'hFEE;
      lim = ($urandom_range(0, 9) < 7) ? DEPTH : int'($urandom_range(0, 7));
      step($urandom_range(0, 9) < 6, ha, $urandom,
           $urandom_range(0, 9) < 6, 1'($urandom), ga, $urandom,
           lim, $urandom_range(0, 9) < 5);
    end
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule